// File: doc/BRIEF.md
# Converter Power Mode Controller

This block holds the digital power state of a sampling converter. A two-bit power mode field from a control register and an active-low sleep pin are combined with the converter's busy and calibration status. The result drives two enables. One powers the analog core. The other keeps the reference and bias alive. Three states exist: fully on, partial power-down (core off, reference on) and full power-down (both off).

In the automatic mode the converter sleeps between samples. A falling edge on the external start input wakes it. The following rising edge requests a conversion. When busy drops at the end of that conversion the block returns to full power-down. A programmable power-up delay, counted in master clocks, gates a ready output. Conversion-start pulses are only issued while ready is high. A start edge that arrives too early is held until ready rises, and a flag marks that this happened. A software start pulse is accepted only while ready is high.

Top module: `cnv_pwr_ctrl`

## Requirements
- R1: After reset the block is in full power-down: core_en_o, ref_en_o, ready_o, conv_start_o and early_start_o are all 0. A mode field of 2'b00 selects sleeping between conversions.
- R2: Mode 2'b00 with sleep_n_i high, or mode 2'b01 at any sleep_n_i level, sets core_en_o and ref_en_o to 1 one clock after the inputs are applied.
- R3: Mode 2'b10 clears core_en_o and ref_en_o one clock after it is applied, regardless of sleep_n_i, busy_i and cal_busy_i.
- R4: Mode 2'b11 gives partial power-down (core_en_o 0, ref_en_o 1) one clock after busy_i is low. While busy_i is high it gives full power (both 1) one clock later.
- R5: In mode 2'b00 with sleep_n_i low, a falling edge on start_i sets core_en_o two clocks after the edge. A falling edge on busy_i clears both enables two clocks after the edge.
- R6: In mode 2'b00 with sleep_n_i low, cal_busy_i high keeps the block fully powered one clock later, whatever sleep_n_i does. When cal_busy_i drops, the block goes to full power-down, never to partial power-down. Partial power-down occurs only in mode 2'b11.
- R7: ready_o is 0 whenever core_en_o is 0. ready_o rises exactly UP_DLY_FULL clocks after core_en_o rises from full power-down, and exactly UP_DLY_PART clocks after it rises from partial power-down.
- R8: A rising edge on start_i while ready_o is 1 produces a one-clock conv_start_o pulse in the next clock. No pulse appears without a request.
- R9: A rising edge on start_i while ready_o is 0 is held. conv_start_o pulses one clock after ready_o rises. early_start_o is set by such an edge, stays 1 through power-down, and clears one clock after the next falling edge on start_i.
- R10: A sw_start_i pulse while ready_o is 1 produces a conv_start_o pulse one clock later. While ready_o is 0 the pulse is dropped and not remembered, so a software start after automatic power-down needs a prior write selecting mode 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_mode_i | input | 2 | Power mode field from the control register |
| sleep_n_i | input | 1 | Active-low sleep pin |
| start_i | input | 1 | External start input; falling edge wakes, rising edge requests a conversion |
| sw_start_i | input | 1 | One-clock software conversion request |
| busy_i | input | 1 | Conversion in progress |
| cal_busy_i | input | 1 | Calibration in progress |
| core_en_o | output | 1 | Analog core power enable |
| ref_en_o | output | 1 | Reference and bias power enable |
| ready_o | output | 1 | Power-up delay has elapsed and the core is on |
| conv_start_o | output | 1 | One-clock conversion start pulse |
| early_start_o | output | 1 | A start edge arrived before ready and was held |

## Verification
The bench targets the edge of the power-up window. It checks ready_o one clock before and at the expected rise, for both the full and the partial delay. A counter with an off-by-one error, or one that used the wrong limit, fails there. A start edge is given well before ready rises, and the scoreboard expects the pulse at one exact cycle. A design that dropped the held request, or fired it at once, is reported. The bench also ends a calibration with the sleep pin low and checks that the reference goes off too, which catches a design that drifts into partial power-down. Software pulses are given while the core is down and in forced-off mode, and the scoreboard flags any pulse that a design wrongly remembered.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

   typedef enum logic [1:0] {
      PS_OFF  = 2'b00,
      PS_PART = 2'b01,
      PS_ON   = 2'b10
   } pwr_state_e;

   localparam logic [1:0] PM_AUTO = 2'b00;
   localparam logic [1:0] PM_RUN  = 2'b01;
   localparam logic [1:0] PM_OFF  = 2'b10;
   localparam logic [1:0] PM_PART = 2'b11;

endpackage

// File: rtl/cpm_mode_decode.sv
module cpm_mode_decode
   import cpm_pkg::*;
(
   input  logic [1:0] mode_i,
   input  logic       sleep_n_i,
   input  logic       cal_i,
   input  logic       busy_i,
   input  logic       awake_i,
   output pwr_state_e target_o
);

   always_comb begin
      target_o = PS_OFF;
      case (mode_i)
         PM_AUTO: begin
            // sleep pin high, a pending wake, a conversion or a calibration holds power
            if (sleep_n_i || awake_i || busy_i || cal_i) target_o = PS_ON;
            else                                         target_o = PS_OFF;
         end
         PM_RUN:  target_o = PS_ON;
         PM_OFF:  target_o = PS_OFF;
         PM_PART: target_o = busy_i ? PS_ON : PS_PART;
         default: target_o = PS_OFF;
      endcase
   end

endmodule

// File: rtl/cpm_wake_track.sv
module cpm_wake_track (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic busy_i,
   output logic start_rise_o,
   output logic start_fall_o,
   output logic awake_o
);

   logic start_q;
   logic busy_q;
   logic awake_q;
   logic busy_fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= 1'b1;
         busy_q  <= 1'b0;
      end else begin
         start_q <= start_i;
         busy_q  <= busy_i;
      end
   end

   assign start_rise_o = ~start_q & start_i;
   assign start_fall_o = start_q & ~start_i;
   assign busy_fall    = busy_q & ~busy_i;

   always_ff @(posedge clk) begin
      if (!rst_n)            awake_q <= 1'b0;
      else if (start_fall_o) awake_q <= 1'b1;
      else if (busy_fall)    awake_q <= 1'b0;
   end

   assign awake_o = awake_q;

   // R5
   wake_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_fall_o |=> awake_o);

endmodule

// File: rtl/cpm_updelay.sv
module cpm_updelay
   import cpm_pkg::*;
#(
   parameter int DLY_FULL   = 20,
   parameter int DLY_PART   = 4,
   parameter bit SPLIT_PART = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  pwr_state_e state_i,
   output logic       ready_o
);

   localparam int MAX_DLY = (DLY_FULL > DLY_PART) ? DLY_FULL : DLY_PART;
   localparam int CNT_W   = $clog2(MAX_DLY + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;
   logic             from_part_q;
   logic             on;

   assign on = (state_i == PS_ON);

   generate
      if (SPLIT_PART) begin : g_split
         assign lim = from_part_q ? CNT_W'(DLY_PART) : CNT_W'(DLY_FULL);
      end else begin : g_single
         assign lim = CNT_W'(DLY_FULL);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         from_part_q <= 1'b0;
      end else if (!on) begin
         cnt_q       <= '0;
         from_part_q <= (state_i == PS_PART);
      end else if (cnt_q != lim) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign ready_o = on && (cnt_q == lim);

   // R7
   ready_after_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> ($past(state_i) == PS_ON));

endmodule

// File: rtl/cpm_start_seq.sv
module cpm_start_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic rise_i,
   input  logic fall_i,
   input  logic sw_start_i,
   input  logic ready_i,
   output logic conv_start_o,
   output logic early_o
);

   logic pend_q;
   logic early_q;
   logic conv_q;
   logic issue;

   assign issue = ready_i & (rise_i | pend_q | sw_start_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         early_q <= 1'b0;
         conv_q  <= 1'b0;
      end else begin
         conv_q <= issue;
         pend_q <= ~ready_i & (pend_q | rise_i);
         if (rise_i && !ready_i) early_q <= 1'b1;
         else if (fall_i)        early_q <= 1'b0;
      end
   end

   assign conv_start_o = conv_q;
   assign early_o      = early_q;

   // R8
   start_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |-> $past(ready_i));

   // R10
   sw_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_start_i && !ready_i) |=> !conv_start_o);

endmodule

// File: rtl/cnv_pwr_ctrl.sv
module cnv_pwr_ctrl
   import cpm_pkg::*;
#(
   parameter int UP_DLY_FULL    = 20,
   parameter int UP_DLY_PART    = 4,
   parameter bit SPLIT_PART_DLY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] pm_mode_i,
   input  logic       sleep_n_i,
   input  logic       start_i,
   input  logic       sw_start_i,
   input  logic       busy_i,
   input  logic       cal_busy_i,
   output logic       core_en_o,
   output logic       ref_en_o,
   output logic       ready_o,
   output logic       conv_start_o,
   output logic       early_start_o
);

   generate
      if (UP_DLY_FULL < 1 || UP_DLY_PART < 1) begin : g_bad_dly
         $error("power-up delays must be at least one clock");
      end
   endgenerate

   pwr_state_e target;
   pwr_state_e pstate_q;
   logic       rise;
   logic       fall;
   logic       awake;

   cpm_wake_track u_wake (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .busy_i       (busy_i),
      .start_rise_o (rise),
      .start_fall_o (fall),
      .awake_o      (awake)
   );

   cpm_mode_decode u_dec (
      .mode_i    (pm_mode_i),
      .sleep_n_i (sleep_n_i),
      .cal_i     (cal_busy_i),
      .busy_i    (busy_i),
      .awake_i   (awake),
      .target_o  (target)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) pstate_q <= PS_OFF;
      else        pstate_q <= target;
   end

   assign core_en_o = (pstate_q == PS_ON);
   assign ref_en_o  = (pstate_q != PS_OFF);

   cpm_updelay #(
      .DLY_FULL   (UP_DLY_FULL),
      .DLY_PART   (UP_DLY_PART),
      .SPLIT_PART (SPLIT_PART_DLY)
   ) u_dly (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_i (pstate_q),
      .ready_o (ready_o)
   );

   cpm_start_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .rise_i       (rise),
      .fall_i       (fall),
      .sw_start_i   (sw_start_i),
      .ready_i      (ready_o),
      .conv_start_o (conv_start_o),
      .early_o      (early_start_o)
   );

   // R3
   forced_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pm_mode_i) == PM_OFF) |-> (!core_en_o && !ref_en_o));

   // R4
   busy_wakes_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pm_mode_i) == PM_PART && $past(busy_i)) |-> core_en_o);

   // R6
   part_only_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_en_o && !core_en_o) |-> ($past(pm_mode_i) == PM_PART));

endmodule

// File: tb/cnv_pwr_ctrl_tb.sv
module cnv_pwr_ctrl_tb;

   localparam int DF = 20;
   localparam int DP = 4;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] pm_mode_i;
   logic       sleep_n_i;
   logic       start_i;
   logic       sw_start_i;
   logic       busy_i;
   logic       cal_busy_i;
   logic       core_en_o;
   logic       ref_en_o;
   logic       ready_o;
   logic       conv_start_o;
   logic       early_start_o;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;
   int exp_q[$];

   always #2.5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   cnv_pwr_ctrl #(
      .UP_DLY_FULL    (DF),
      .UP_DLY_PART    (DP),
      .SPLIT_PART_DLY (1'b1)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .pm_mode_i     (pm_mode_i),
      .sleep_n_i     (sleep_n_i),
      .start_i       (start_i),
      .sw_start_i    (sw_start_i),
      .busy_i        (busy_i),
      .cal_busy_i    (cal_busy_i),
      .core_en_o     (core_en_o),
      .ref_en_o      (ref_en_o),
      .ready_o       (ready_o),
      .conv_start_o  (conv_start_o),
      .early_start_o (early_start_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_pwr(input string req, input bit core, input bit refe);
      chk(core_en_o == core, {req, " core_en"}, int'(core_en_o), int'(core));
      chk(ref_en_o == refe, {req, " ref_en"}, int'(ref_en_o), int'(refe));
   endtask

   task automatic busy_pulse();
      busy_i = 1'b1;
      step(3);
      busy_i = 1'b0;
      step(3);
   endtask

   // monitor: every conversion pulse must match the next expected cycle (R8)
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done && conv_start_o) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected conv_start", cyc, -1);
         end else begin
            int e;
            e = exp_q.pop_front();
            chk(cyc == e, "R8 conv_start cycle", cyc, e);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         chk(1'b0, "watchdog", cyc, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; pm_mode_i = 2'b00; sleep_n_i = 1'b0; start_i = 1'b1;
      sw_start_i = 1'b0; busy_i = 1'b0; cal_busy_i = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      chk_pwr("R1", 1'b0, 1'b0);
      chk(ready_o == 1'b0, "R1 ready", int'(ready_o), 0);
      chk(early_start_o == 1'b0, "R1 early", int'(early_start_o), 0);

      // R10 software start while powered down is dropped
      sw_start_i = 1'b1; step(1); sw_start_i = 1'b0;
      step(3);
      chk(ready_o == 1'b0, "R10 ready while down", int'(ready_o), 0);
      chk_pwr("R10 still down", 1'b0, 1'b0);

      // R5 / R7 / R8 wake by falling edge, convert, sleep on busy fall
      start_i = 1'b0;
      step(1); chk_pwr("R5 one clock after fall", 1'b0, 1'b0);
      step(1); chk_pwr("R5 two clocks after fall", 1'b1, 1'b1);
      chk(ready_o == 1'b0, "R7 ready low at wake", int'(ready_o), 0);
      step(DF - 1); chk(ready_o == 1'b0, "R7 ready before full delay", int'(ready_o), 0);
      step(1); chk(ready_o == 1'b1, "R7 ready at full delay", int'(ready_o), 1);
      start_i = 1'b1; exp_q.push_back(cyc + 1);
      step(2);
      chk(early_start_o == 1'b0, "R9 no early flag on timely start", int'(early_start_o), 0);
      busy_i = 1'b1; step(3); busy_i = 1'b0;
      step(1); chk_pwr("R5 one clock after busy fall", 1'b1, 1'b1);
      step(1); chk_pwr("R5 two clocks after busy fall", 1'b0, 1'b0);
      chk(ready_o == 1'b0, "R7 ready low when down", int'(ready_o), 0);

      // R9 early start edge is held until ready
      start_i = 1'b0; step(3);
      start_i = 1'b1; exp_q.push_back(cyc + DF);
      step(2);
      chk(early_start_o == 1'b1, "R9 early flag set", int'(early_start_o), 1);
      step(DF + 2);
      busy_pulse();
      chk_pwr("R9 down after held conversion", 1'b0, 1'b0);
      chk(early_start_o == 1'b1, "R9 early flag kept", int'(early_start_o), 1);
      start_i = 1'b0;
      step(1);
      chk(early_start_o == 1'b0, "R9 early flag cleared by fall", int'(early_start_o), 0);
      step(DF + 1);
      chk(ready_o == 1'b1, "R7 ready second wake", int'(ready_o), 1);
      start_i = 1'b1; exp_q.push_back(cyc + 1);
      step(2);
      busy_pulse();
      chk_pwr("R5 down again", 1'b0, 1'b0);

      // R2 / R10 explicit run mode then software start
      pm_mode_i = 2'b01;
      step(1); chk_pwr("R2 run mode with sleep low", 1'b1, 1'b1);
      step(DF - 1); chk(ready_o == 1'b0, "R7 run mode before delay", int'(ready_o), 0);
      step(1); chk(ready_o == 1'b1, "R7 run mode ready", int'(ready_o), 1);
      sw_start_i = 1'b1; exp_q.push_back(cyc + 1);
      step(1); sw_start_i = 1'b0;
      step(2);

      // R2 auto mode with sleep high stays on; sleep low powers down
      pm_mode_i = 2'b00; sleep_n_i = 1'b1;
      step(1); chk_pwr("R2 auto mode sleep high", 1'b1, 1'b1);
      sleep_n_i = 1'b0;
      step(1); chk_pwr("R2 auto mode sleep low", 1'b0, 1'b0);

      // R6 calibration holds power and ends in full power-down
      cal_busy_i = 1'b1;
      step(1); chk_pwr("R6 calibration on", 1'b1, 1'b1);
      sleep_n_i = 1'b1; step(1); sleep_n_i = 1'b0; step(1);
      chk_pwr("R6 sleep ignored in calibration", 1'b1, 1'b1);
      cal_busy_i = 1'b0;
      step(1); chk_pwr("R6 full not partial after calibration", 1'b0, 1'b0);

      // R3 forced off ignores sleep, busy, calibration and software start
      pm_mode_i = 2'b10; sleep_n_i = 1'b1; busy_i = 1'b1; cal_busy_i = 1'b1;
      step(1); chk_pwr("R3 forced off", 1'b0, 1'b0);
      sw_start_i = 1'b1; step(1); sw_start_i = 1'b0;
      step(2);
      chk_pwr("R3 still off", 1'b0, 1'b0);
      chk(ready_o == 1'b0, "R10 ready low in forced off", int'(ready_o), 0);
      busy_i = 1'b0; cal_busy_i = 1'b0; sleep_n_i = 1'b0;
      step(2);

      // R4 partial mode, busy lifts to full power with short delay
      pm_mode_i = 2'b11;
      step(1); chk_pwr("R4 partial", 1'b0, 1'b1);
      busy_i = 1'b1;
      step(1); chk_pwr("R4 busy in partial mode", 1'b1, 1'b1);
      step(DP - 1); chk(ready_o == 1'b0, "R7 before partial delay", int'(ready_o), 0);
      step(1); chk(ready_o == 1'b1, "R7 partial delay", int'(ready_o), 1);
      busy_i = 1'b0;
      step(1); chk_pwr("R4 back to partial", 1'b0, 1'b1);
      chk(ready_o == 1'b0, "R7 ready low in partial", int'(ready_o), 0);

      step(5);
      chk(exp_q.size() == 0, "R8 all expected pulses seen", exp_q.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule